// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point operand storage for a core. The storage is one array of 32-bit slots that can be reached at three sizes. A single-size access touches one slot. A double-size access touches an aligned pair of slots. A quad-size access touches an aligned group of four slots. Because the three views share the same slots, a write at one size can be read back at another size.

The block has one combinational read port and one write port. The write port updates storage on the rising clock edge. Each port takes a 6-bit register number and a 2-bit size code, and carries data right-aligned in a 128-bit bus. The `EXTENDED` parameter doubles the storage from 32 to 64 slots. The added upper half can be reached at double and quad size only. A misaligned, out-of-range or reserved-size access raises a per-port illegal flag. An illegal write changes no slot, and an illegal read returns zeros.

Top module: `fp_alias_regfile`

## Requirements
- R1: A synchronous active-low reset clears every slot to zero.
- R2: A single-size access to number n (0 to 31) maps to slot n. Its data occupies bits 31:0, and a single read returns zeros in bits 127:32.
- R3: A double-size access to an even number d maps to slots d and d+1. Slot d is bits 63:32 and slot d+1 is bits 31:0. Bits 127:64 read as zero.
- R4: A quad-size access to a number q that is a multiple of 4 maps to slots q to q+3. Slot q is bits 127:96 and slot q+3 is bits 31:0.
- R5: The size code is 00 for single, 01 for double and 10 for quad. Code 11 is reserved and always illegal.
- R6: An odd double number, or a quad number that is not a multiple of 4, is illegal.
- R7: A single-size access to any number at or above 32 is illegal.
- R8: With `EXTENDED`=1, numbers 32 to 63 reach slots 32 to 63 at double and quad size. With `EXTENDED`=0, any double or quad number at or above 32 is illegal.
- R9: A legal write changes only the slots its size covers. Every other slot keeps its value.
- R10: A read in the same cycle as a write to an overlapping slot returns the value from before the write. The new value is visible from the following cycle.
- R11: `rd_illegal` follows the read inputs combinationally. `wr_illegal` is high only when `wr_en` is high and the write is illegal. An illegal write changes no slot, and an illegal read returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_num | input | 6 | Read register number |
| rd_size | input | 2 | Read size code |
| rd_data | output | 128 | Read data, right-aligned |
| rd_illegal | output | 1 | Read access is illegal |
| wr_en | input | 1 | Write request |
| wr_num | input | 6 | Write register number |
| wr_size | input | 2 | Write size code |
| wr_data | input | 128 | Write data, right-aligned |
| wr_illegal | output | 1 | Requested write is illegal and was dropped |

## Verification
A wrong slot enable or a wrong lane select leaves a slot holding a stale or misplaced word. That error stays hidden until the slot is read. The bench therefore reads every written region back at a different size on the next cycle. A single-size readback exposes a word that landed in the wrong half. A quad-size readback exposes a neighbour that was overwritten. A decoding error in the legality logic shows in the same cycle, either on an illegal flag or as nonzero data on an illegal read. A suppressed write that leaks into storage shows on the first read of the slot it touched.

// File: rtl/fprf_pkg.sv
// Package: shared size encoding and lane geometry for the aliased FP register file.
// Assumes: every access is at most four 32-bit lanes wide.
package fprf_pkg;
    typedef enum logic [1:0] {
        SZ_SINGLE = 2'b00,
        SZ_DOUBLE = 2'b01,
        SZ_QUAD   = 2'b10,
        SZ_RSVD   = 2'b11
    } fp_size_e;

    localparam int LANES_MAX = 4;
endpackage

// File: rtl/fprf_decode.sv
// Module: fprf_decode
// Turns a register number and size code into a legality bit and a slot span.
// Assumes: SLOTS is a multiple of 4, and single-size reach is fixed at SINGLE_SLOTS.
module fprf_decode #(
    parameter int NUM_W        = 6,
    parameter int SLOTS        = 64,
    parameter int SINGLE_SLOTS = 32
) (
    input  logic [NUM_W-1:0] num,
    input  logic [1:0]       size,
    output logic             legal,
    output logic [2:0]       span
);
    import fprf_pkg::*;

    // Purpose: classify the access and pick how many slots it covers.
    always_comb begin
        legal = 1'b0;
        span  = 3'd1;
        case (fp_size_e'(size))
            SZ_SINGLE: begin
                span  = 3'd1;
                legal = int'(num) < SINGLE_SLOTS;
            end
            SZ_DOUBLE: begin
                span  = 3'd2;
                legal = (num[0] == 1'b0) && (int'(num) < SLOTS);
            end
            SZ_QUAD: begin
                span  = 3'd4;
                legal = (num[1:0] == 2'b00) && (int'(num) < SLOTS);
            end
            default: begin
                span  = 3'd1;
                legal = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fprf_store.sv
// Module: fprf_store
// Slot array with one write port; a write spans 1, 2 or 4 consecutive slots.
// Assumes: base and span come from a legal decode whenever we is high.
module fprf_store #(
    parameter int NUM_W  = 6,
    parameter int SLOTS  = 64,
    parameter int LANE_W = 32,
    localparam int DATA_W = fprf_pkg::LANES_MAX * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [NUM_W-1:0]        base,
    input  logic [2:0]              span,
    input  logic [DATA_W-1:0]       wdata,
    output logic [SLOTS*LANE_W-1:0] slots_flat
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic              hit;
        logic [LANE_W-1:0] d;
        logic [LANE_W-1:0] q;

        // Purpose: decide whether this slot is covered and which write lane feeds it.
        always_comb begin : p_sel
            int rel;
            int lane;
            rel  = i - int'(base);
            hit  = we && (rel >= 0) && (rel < int'(span));
            lane = hit ? (int'(span) - 1 - rel) : 0;
            d    = wdata[lane*LANE_W +: LANE_W];
        end

        // Purpose: hold the slot value, cleared by reset and loaded on a covering write.
        always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= d;
        end

        assign slots_flat[i*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/fprf_gather.sv
// Module: fprf_gather
// Assembles read data from the slot array, lowest-numbered slot in the top lane.
// Assumes: base and span describe an in-range access whenever legal is high.
module fprf_gather #(
    parameter int NUM_W  = 6,
    parameter int SLOTS  = 64,
    parameter int LANE_W = 32,
    localparam int DATA_W = fprf_pkg::LANES_MAX * LANE_W
) (
    input  logic [SLOTS*LANE_W-1:0] slots_flat,
    input  logic [NUM_W-1:0]        base,
    input  logic [2:0]              span,
    input  logic                    legal,
    output logic [DATA_W-1:0]       rdata
);
    for (genvar k = 0; k < fprf_pkg::LANES_MAX; k++) begin : g_lane
        // Purpose: fill output lane k from its slot or with zeros.
        always_comb begin : p_lane
            int idx;
            logic use_lane;
            use_lane = legal && (k < int'(span));
            idx      = use_lane ? (int'(base) + int'(span) - 1 - k) : 0;
            rdata[k*LANE_W +: LANE_W] = use_lane ? slots_flat[idx*LANE_W +: LANE_W] : '0;
        end
    end
endmodule

// File: rtl/fp_alias_regfile.sv
// Module: fp_alias_regfile (top)
// FP register file seen at single, double and quad size over one shared slot array.
// Assumes: read is combinational, write lands on the rising edge; EXTENDED adds an
// upper bank reachable only at double or quad size.
module fp_alias_regfile #(
    parameter bit EXTENDED = 1'b1,
    parameter int NUM_W    = 6,
    parameter int LANE_W   = 32,
    localparam int DATA_W  = fprf_pkg::LANES_MAX * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_W-1:0]  rd_num,
    input  logic [1:0]        rd_size,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_illegal,
    input  logic              wr_en,
    input  logic [NUM_W-1:0]  wr_num,
    input  logic [1:0]        wr_size,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_illegal
);
    localparam int SINGLE_SLOTS = 32;
    localparam int SLOTS        = EXTENDED ? 2 * SINGLE_SLOTS : SINGLE_SLOTS;

    logic                    r_legal;
    logic                    w_legal;
    logic [2:0]              r_span;
    logic [2:0]              w_span;
    logic [SLOTS*LANE_W-1:0] slots_flat;

    fprf_decode #(.NUM_W(NUM_W), .SLOTS(SLOTS), .SINGLE_SLOTS(SINGLE_SLOTS)) u_rdec (
        .num(rd_num), .size(rd_size), .legal(r_legal), .span(r_span)
    );

    fprf_decode #(.NUM_W(NUM_W), .SLOTS(SLOTS), .SINGLE_SLOTS(SINGLE_SLOTS)) u_wdec (
        .num(wr_num), .size(wr_size), .legal(w_legal), .span(w_span)
    );

    fprf_store #(.NUM_W(NUM_W), .SLOTS(SLOTS), .LANE_W(LANE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_en && w_legal), .base(wr_num),
        .span(w_span), .wdata(wr_data), .slots_flat(slots_flat)
    );

    fprf_gather #(.NUM_W(NUM_W), .SLOTS(SLOTS), .LANE_W(LANE_W)) u_gather (
        .slots_flat(slots_flat), .base(rd_num), .span(r_span), .legal(r_legal),
        .rdata(rd_data)
    );

    // Purpose: report illegal accesses, the write flag only for requested writes.
    assign rd_illegal = !r_legal;
    assign wr_illegal = wr_en && !w_legal;
endmodule

// File: rtl/fprf_checker.sv
// Module: fprf_checker
// Port-level properties of the aliased FP register file, bound to every instance.
// Assumes: read port is combinational and observed at each clock edge.
module fprf_checker #(
    parameter int NUM_W  = 6,
    parameter int LANE_W = 32,
    localparam int DATA_W = fprf_pkg::LANES_MAX * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_W-1:0]  rd_num,
    input logic [1:0]        rd_size,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_illegal,
    input logic              wr_en,
    input logic [NUM_W-1:0]  wr_num,
    input logic [1:0]        wr_size,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_illegal
);
    import fprf_pkg::*;

    // R4 with R10: a legal quad write is read back whole on the next cycle.
    a_r4_quad_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_illegal && wr_size == SZ_QUAD) |=>
        ((rd_size == SZ_QUAD && rd_num == $past(wr_num)) -> (rd_data == $past(wr_data))));

    a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_SINGLE) |-> (rd_data[DATA_W-1:LANE_W] == '0));

    a_r6_odd_double_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_DOUBLE && rd_num[0]) |-> rd_illegal);

    a_r6_misaligned_quad_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_QUAD && rd_num[1:0] != 2'b00) |-> rd_illegal);

    a_r7_single_high_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_SINGLE && int'(rd_num) >= 32) |-> rd_illegal);

    a_r5_reserved_size_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size == SZ_RSVD) |-> rd_illegal);

    a_r11_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    a_r11_no_request_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_illegal);
endmodule

bind fp_alias_regfile fprf_checker #(.NUM_W(NUM_W), .LANE_W(LANE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_size(rd_size),
    .rd_data(rd_data), .rd_illegal(rd_illegal), .wr_en(wr_en), .wr_num(wr_num),
    .wr_size(wr_size), .wr_data(wr_data), .wr_illegal(wr_illegal)
);

// File: tb/fp_alias_regfile_test.sv
// Scoreboard bench: the driver computes expected read results from a slot model and
// queues them; the monitor compares the port outputs mid-cycle.
module fp_alias_regfile_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   rd_num = '0;
    logic [1:0]   rd_size = '0;
    logic [127:0] rd_data;
    logic         rd_illegal;
    logic         wr_en = 1'b0;
    logic [5:0]   wr_num = '0;
    logic [1:0]   wr_size = '0;
    logic [127:0] wr_data = '0;
    logic         wr_illegal;

    logic [5:0]   b_rd_num = '0;
    logic [1:0]   b_rd_size = '0;
    logic [127:0] b_rd_data;
    logic         b_rd_illegal;
    logic         b_wr_en = 1'b0;
    logic [5:0]   b_wr_num = '0;
    logic [1:0]   b_wr_size = '0;
    logic         b_wr_illegal;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [64];

    typedef struct {
        string        tag;
        logic [127:0] data;
        bit           rill;
        bit           will;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    fp_alias_regfile #(.EXTENDED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .rd_num(rd_num), .rd_size(rd_size),
        .rd_data(rd_data), .rd_illegal(rd_illegal), .wr_en(wr_en), .wr_num(wr_num),
        .wr_size(wr_size), .wr_data(wr_data), .wr_illegal(wr_illegal)
    );

    fp_alias_regfile #(.EXTENDED(1'b0)) uut_base (
        .clk(clk), .rst_n(rst_n), .rd_num(b_rd_num), .rd_size(b_rd_size),
        .rd_data(b_rd_data), .rd_illegal(b_rd_illegal), .wr_en(b_wr_en),
        .wr_num(b_wr_num), .wr_size(b_wr_size), .wr_data(128'h0),
        .wr_illegal(b_wr_illegal)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected legality and data for an access, from the requirement text.
    function automatic void model_access(input logic [5:0] n, input logic [1:0] s,
                                         input bit ext, output bit ill,
                                         output int span);
        int lim = ext ? 64 : 32;
        case (s)
            2'b00: begin span = 1; ill = (int'(n) >= 32); end
            2'b01: begin span = 2; ill = n[0] || (int'(n) >= lim); end
            2'b10: begin span = 4; ill = (n[1:0] != 2'b00) || (int'(n) >= lim); end
            default: begin span = 1; ill = 1'b1; end
        endcase
    endfunction

    task automatic op(string tag, bit we, logic [5:0] wn, logic [1:0] ws,
                      logic [127:0] wd, logic [5:0] rn, logic [1:0] rs);
        exp_t e;
        bit   ill;
        int   span;
        @(negedge clk);
        rst_n = 1'b1;
        wr_en = we; wr_num = wn; wr_size = ws; wr_data = wd;
        rd_num = rn; rd_size = rs;
        e.tag  = tag;
        e.data = '0;
        model_access(rn, rs, 1'b1, ill, span);
        e.rill = ill;
        if (!ill)
            for (int k = 0; k < span; k++) e.data[k*32 +: 32] = model[int'(rn) + span - 1 - k];
        model_access(wn, ws, 1'b1, ill, span);
        e.will = we && ill;
        sb.push_back(e);
        if (we && !ill)
            for (int k = 0; k < span; k++) model[int'(wn) + span - 1 - k] = wd[k*32 +: 32];
    endtask

    task automatic rd(string tag, logic [5:0] rn, logic [1:0] rs);
        op(tag, 1'b0, 6'd0, 2'b00, 128'h0, rn, rs);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < 64; i++) model[i] = '0;
    endtask

    // Monitor: compare the current cycle's outputs against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " data"}, rd_data, e.data);
                chk({e.tag, " rd_illegal"}, {127'b0, rd_illegal}, {127'b0, e.rill});
                chk({e.tag, " wr_illegal"}, {127'b0, wr_illegal}, {127'b0, e.will});
            end
        end
    end

    initial begin
        #(100000 * 20);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 32'hDEAD_0000 | i;
        do_reset();
        @(negedge clk);
        rd("R1 reset quad 0", 6'd0, 2'b10);
        rd("R1 reset double 62", 6'd62, 2'b01);
        // R10: same-cycle read returns old value; R2 single readback.
        op("R10 read during write", 1'b1, 6'd3, 2'b00, 128'hA1A2A3A4, 6'd3, 2'b00);
        rd("R2 single 3", 6'd3, 2'b00);
        rd("R3 double 2 alias", 6'd2, 2'b01);
        op("R3 write double 4", 1'b1, 6'd4, 2'b01, 128'hB1B2B3B4_C1C2C3C4, 6'd4, 2'b00);
        rd("R3 single 4 upper", 6'd4, 2'b00);
        rd("R3 single 5 lower", 6'd5, 2'b00);
        op("R4 write quad 8", 1'b1, 6'd8, 2'b10,
           128'hD0D0D0D0_E0E0E0E0_F0F0F0F0_12345678, 6'd8, 2'b01);
        rd("R4 double 8", 6'd8, 2'b01);
        rd("R4 double 10", 6'd10, 2'b01);
        rd("R4 single 11", 6'd11, 2'b00);
        op("R9 single 9 in quad", 1'b1, 6'd9, 2'b00, 128'h99990000, 6'd8, 2'b10);
        rd("R9 quad 8 after", 6'd8, 2'b10);
        op("R6 odd double write", 1'b1, 6'd5, 2'b01, 128'hFFFF_FFFF_FFFF_FFFF, 6'd5, 2'b01);
        rd("R6 quad 4 untouched", 6'd4, 2'b10);
        op("R6 misaligned quad", 1'b1, 6'd6, 2'b10, {4{32'h66666666}}, 6'd6, 2'b10);
        rd("R6 quad 4 still", 6'd4, 2'b10);
        op("R5 reserved size", 1'b1, 6'd0, 2'b11, {4{32'h55555555}}, 6'd0, 2'b11);
        rd("R5 quad 0 untouched", 6'd0, 2'b10);
        op("R7 single 40 write", 1'b1, 6'd40, 2'b00, 128'h77777777, 6'd33, 2'b00);
        rd("R7 double 40 untouched", 6'd40, 2'b01);
        op("R8 upper double 40", 1'b1, 6'd40, 2'b01, 128'h40404040_41414141, 6'd40, 2'b10);
        rd("R8 upper quad 40", 6'd40, 2'b10);
        op("R8 upper quad 60", 1'b1, 6'd60, 2'b10,
           128'h60606060_61616161_62626262_63636363, 6'd62, 2'b01);
        rd("R8 upper double 62", 6'd62, 2'b01);
        rd("R8 upper double 60", 6'd60, 2'b01);
        op("R11 no request no flag", 1'b0, 6'd7, 2'b01, 128'h0, 6'd8, 2'b10);
        // R8: base instance rejects the upper bank.
        @(negedge clk);
        wr_en = 1'b0; sb.delete();
        b_rd_num = 6'd32; b_rd_size = 2'b01; b_wr_en = 1'b1; b_wr_num = 6'd36; b_wr_size = 2'b10;
        #5;
        chk("R8 base double 32 flag", {127'b0, b_rd_illegal}, 128'd1);
        chk("R8 base double 32 data", b_rd_data, 128'h0);
        chk("R8 base quad 36 write flag", {127'b0, b_wr_illegal}, 128'd1);
        @(negedge clk);
        b_wr_en = 1'b0; b_rd_num = 6'd30; b_rd_size = 2'b01;
        #5;
        chk("R8 base double 30 legal", {127'b0, b_rd_illegal}, 128'd0);
        // R1: reset mid-run clears written slots.
        do_reset();
        rd("R1 reset clears quad 8", 6'd8, 2'b10);
        rd("R1 reset clears quad 60", 6'd60, 2'b10);
        @(negedge clk);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule